// File: doc/BRIEF.md
# MIL-STD-1553 Manchester Word Encoder

This block turns one 16-bit word into a MIL-STD-1553 bit stream on a pair of active-low line-driver outputs. It runs from a single clock, and a built-in prescaler makes one half-bit out of `HALF_DIV` clock cycles. The default of 6 fits a clock at twelve times the bit rate; a value of 1 treats the clock as the twice-bit-rate send clock. The block produces a free-running shift clock at the bit rate. Each word lasts 20 bit periods: a three-bit-time sync character, sixteen Manchester II data bits with the most significant bit first, and one parity bit that makes the total of ones odd.

The caller raises `enc_en`, and the block samples it on a falling edge of the shift clock. On the next rising edge the word begins, and `sync_sel` is sampled on that same edge to choose a command or a data sync. While `send_data` is high the caller presents the data serially on `sdi`. The block samples `sdi` on each rising shift-clock edge that closes a `send_data` period. If enable is still high when it is sampled in the parity bit, the next word follows with no gap. `oinh_n` low silences the line without touching the sequencing. `mrst` aborts everything immediately.

Top module: `m1553_word_encoder`

## Requirements
- R1: While `mrst` is high and after its release with no word started, `sclk` is high, `send_data` is low, and both `line_pos_n` and `line_neg_n` are high.
- R2: `sclk` is high for the first `HALF_DIV` clock cycles of each bit period and low for the next `HALF_DIV` cycles. It changes only on a half-bit boundary.
- R3: `enc_en` is sampled on the falling `sclk` edge when idle, or in the parity bit of a word. If it is high, the word's first sync half-bit starts at the next rising `sclk` edge. `sync_sel` is sampled on that rising edge, with 1 selecting a command sync and 0 a data sync.
- R4: "Positive" means `line_pos_n`=0 and `line_neg_n`=1, and "negative" is the reverse. A command sync is three positive half-bits followed by three negative half-bits. A data sync is three negative half-bits followed by three positive half-bits.
- R5: `send_data` is high for exactly bit periods 1 to 16 of a word, where period 0 is the first sync bit. `sdi` is sampled on the rising `sclk` edge that ends each of those periods. The first sample is data bit 15 and the last is bit 0.
- R6: Data bit 15-k is sent in bit period 3+k. A one is a positive half-bit followed by a negative half-bit. A zero is the reverse.
- R7: Bit period 19 carries a parity bit, Manchester-coded like data. The parity bit is 1 when the 16 data bits hold an even number of ones.
- R8: If `enc_en` is high when sampled in bit period 19, the next word's sync starts at the very next rising `sclk` edge. Otherwise both line outputs return high and stay high.
- R9: While `oinh_n` is low, both line outputs are high. When it returns high, the outputs continue the word exactly as if no inhibit had occurred.
- R10: `mrst` high aborts any word at once and clears the prescaler and the shift-clock phase. A word started after the release is encoded completely.
- R11: `line_pos_n` and `line_neg_n` are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `HALF_DIV` cycles per half-bit |
| mrst | input | 1 | Asynchronous master reset, active high |
| enc_en | input | 1 | Request to encode words |
| sync_sel | input | 1 | 1 selects a command sync, 0 a data sync |
| sdi | input | 1 | Serial NRZ data, MSB first |
| oinh_n | input | 1 | Output inhibit, active low |
| sclk | output | 1 | Shift clock at the bit rate |
| send_data | output | 1 | High while serial data is requested |
| line_pos_n | output | 1 | Active-low drive for the positive line state |
| line_neg_n | output | 1 | Active-low drive for the negative line state |

## Verification
Two events can fall in the same rising shift-clock edge. The parity bit of one word ends on that edge, and a back-to-back word begins on it, taking in a new `sync_sel` and restarting the parity accumulation. The bench holds `enc_en` high across three words with differing sync types and data. It changes `sync_sel` in mid-word so that only the value at each word's start may count. A behavioural model that predicts every half-bit compares the line outputs and `send_data` on every clock. Any gap, any stale parity or any wrong sync type shows up as a mismatch in bit period 19 or in period 0 of the next word.

// File: rtl/m1553_word_encoder.sv
module m1553_word_encoder #(
  parameter int HALF_DIV  = 6,
  parameter int DATA_BITS = 16
) (
  input  logic clk,
  input  logic mrst,
  input  logic enc_en,
  input  logic sync_sel,
  input  logic sdi,
  input  logic oinh_n,
  output logic sclk,
  output logic send_data,
  output logic line_pos_n,
  output logic line_neg_n
);

  localparam int SYNC_SLOTS = 3;
  localparam int LAST_SLOT  = SYNC_SLOTS + DATA_BITS;
  localparam int SW         = $clog2(LAST_SLOT + 1);
  localparam logic [SW-1:0] S_LAST    = SW'(LAST_SLOT);
  localparam logic [SW-1:0] S_SD_LO   = SW'(1);
  localparam logic [SW-1:0] S_SD_HI   = SW'(DATA_BITS);
  localparam logic [SW-1:0] S_SMP_LO  = SW'(2);
  localparam logic [SW-1:0] S_SMP_HI  = SW'(DATA_BITS + 1);
  localparam logic [SW-1:0] S_TX_LO   = SW'(SYNC_SLOTS);
  localparam logic [SW-1:0] S_TX_HI   = SW'(LAST_SLOT - 1);
  localparam logic [SW-1:0] S_SYNC_N  = SW'(SYNC_SLOTS);

  logic tick;

  generate
    if (HALF_DIV > 1) begin : g_pre
      localparam int DW = $clog2(HALF_DIV);
      localparam logic [DW-1:0] D_TOP = DW'(HALF_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or posedge mrst) begin
        if (mrst)                div_q <= '0;
        else if (div_q == D_TOP) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == D_TOP);
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  logic          ph, active, armed, cmd, nxt, txb, par;
  logic [SW-1:0] slot, nslot;
  logic          mid_edge, bit_edge, go_on, starting;

  assign mid_edge = tick & ~ph;
  assign bit_edge = tick & ph;
  assign go_on    = active & (slot != S_LAST);
  assign starting = ~go_on & armed;
  assign nslot    = go_on ? slot + 1'b1 : '0;

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      ph <= 1'b0; active <= 1'b0; armed <= 1'b0; slot <= '0;
      cmd <= 1'b0; nxt <= 1'b0; txb <= 1'b0; par <= 1'b0;
    end else if (mid_edge) begin
      ph    <= 1'b1;
      armed <= enc_en & (~active | (slot == S_LAST));
    end else if (bit_edge) begin
      ph     <= 1'b0;
      armed  <= 1'b0;
      slot   <= nslot;
      active <= go_on | armed;
      if (starting) begin
        cmd <= sync_sel;
        par <= 1'b0;
      end
      if (go_on && nslot >= S_SMP_LO && nslot <= S_SMP_HI) begin
        nxt <= sdi;
        par <= par ^ sdi;
      end
      if (go_on && nslot >= S_TX_LO && nslot <= S_TX_HI) txb <= nxt;
      if (go_on && nslot == S_LAST) txb <= ~par;
    end
  end

  logic sync_hi, pos, drive;

  assign sync_hi    = (slot == '0) | ((slot == SW'(1)) & ~ph);
  assign pos        = (slot < S_SYNC_N) ? (cmd ? sync_hi : ~sync_hi) : (txb ^ ph);
  assign drive      = active & oinh_n;
  assign sclk       = ~ph;
  assign send_data  = active & (slot >= S_SD_LO) & (slot <= S_SD_HI);
  assign line_pos_n = ~(drive & pos);
  assign line_neg_n = ~(drive & ~pos);

  // R2
  sclk_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    !tick |=> $stable(sclk));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (mrst)
    !(!line_pos_n && !line_neg_n));

  // R6
  mid_flip_chk: assert property (@(posedge clk) disable iff (mrst)
    (mid_edge && active && slot >= S_TX_LO) |=>
      (!oinh_n || !$past(oinh_n) || line_pos_n != $past(line_pos_n)));

  // R5
  sd_edge_chk: assert property (@(posedge clk) disable iff (mrst)
    !$stable(send_data) |-> $rose(sclk));

  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (mrst)
    $rose(active) |-> $rose(sclk));

endmodule

// File: tb/sim_m1553_word_encoder.sv
module sim_m1553_word_encoder;
  localparam int CLK_P    = 10;
  localparam int HALF_DIV = 6;

  logic clk = 1'b0;
  logic mrst = 1'b1, en = 1'b0, sync_sel = 1'b0, sdi = 1'b1, oinh_n = 1'b1;
  logic sclk, send_data, line_pos_n, line_neg_n;

  m1553_word_encoder #(.HALF_DIV(HALF_DIV), .DATA_BITS(16)) u0 (
    .clk(clk), .mrst(mrst), .enc_en(en), .sync_sel(sync_sel), .sdi(sdi),
    .oinh_n(oinh_n), .sclk(sclk), .send_data(send_data),
    .line_pos_n(line_pos_n), .line_neg_n(line_neg_n));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int cdv = 0, hc = 0, m_slot = -1, m_words = 0;
  bit arm = 0, m_cmd = 0, started = 0;
  logic [15:0] m_data = '0;
  logic [15:0] q[$];

  always @(posedge clk) begin
    if (mrst) begin
      cdv = 0; hc = 0; m_slot = -1; arm = 0;
    end else if (cdv == HALF_DIV - 1) begin
      cdv = 0;
      if (hc % 2 == 0) begin
        arm = (m_slot < 0 || m_slot == 19) ? en : 1'b0;
      end else begin
        if (m_slot >= 0 && m_slot < 19) m_slot++;
        else if (arm) begin
          m_slot = 0; m_cmd = sync_sel; started = 1; m_words++;
          m_data = (q.size() > 0) ? q.pop_front() : 16'h0000;
        end else m_slot = -1;
        arm = 0;
      end
      hc++;
    end else cdv++;
  end

  function automatic bit exp_pos(int s, int h, bit c, logic [15:0] d);
    int hi;
    if (s < 3) begin
      hi = s * 2 + h;
      return c ? (hi < 3) : (hi >= 3);
    end else if (s < 19) return d[18 - s] ^ h[0];
    else return (~^d) ^ h[0];
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (!done) begin
      logic e_sclk, e_sd, e_p, e_n, p;
      string tag;
      if (mrst) begin
        e_sclk = 1; e_sd = 0; e_p = 1; e_n = 1; tag = "R10";
      end else begin
        e_sclk = (hc % 2 == 0);
        e_sd   = (m_slot >= 1 && m_slot <= 16);
        if (m_slot < 0) begin
          e_p = 1; e_n = 1; tag = started ? "R8" : "R1";
        end else begin
          p = exp_pos(m_slot, hc % 2, m_cmd, m_data);
          e_p = !(oinh_n && p); e_n = !(oinh_n && !p);
          if (!oinh_n) tag = "R9";
          else if (m_slot == 0 && hc % 2 == 0) tag = "R3";
          else if (m_slot < 3) tag = "R4";
          else if (m_slot < 19) tag = "R6";
          else tag = "R7";
        end
      end
      chk(sclk, e_sclk, "R2");
      chk(send_data, e_sd, "R5");
      chk(line_pos_n, e_p, tag);
      chk(line_neg_n, e_n, tag);
      chk(!(!line_pos_n && !line_neg_n), 1'b1, "R11");
      sdi = (m_slot >= 1 && m_slot <= 16) ? m_data[16 - m_slot] : 1'b1;
    end
  end

  task automatic wait_slot(int s);
    while (m_slot != s) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_slot != -1) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic one_word(bit c, logic [15:0] d);
    q.push_back(d);
    sync_sel = c; en = 1;
    wait_slot(0);
    en = 0;
    @(negedge clk);
    wait_idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    mrst = 0;
    repeat (40) @(negedge clk);
    // R4 R6 R7: command sync, mixed data
    one_word(1, 16'hA5C3);
    // R4 R7: data sync, all zeros (parity one)
    one_word(0, 16'h0000);
    // R8: back-to-back, sync_sel changed mid-word
    base = m_words;
    q.push_back(16'hFFFF); q.push_back(16'h8001); q.push_back(16'h1234);
    sync_sel = 1; en = 1;
    while (m_words != base + 1) @(negedge clk);
    wait_slot(2); sync_sel = 0;
    while (m_words != base + 2) @(negedge clk);
    wait_slot(5); sync_sel = 1;
    while (m_words != base + 3) @(negedge clk);
    wait_slot(5); en = 0; sync_sel = 0;
    @(negedge clk);
    wait_idle();
    // R9: inhibit in mid-word
    q.push_back(16'h5A5A);
    sync_sel = 1; en = 1;
    wait_slot(0); en = 0;
    wait_slot(4); oinh_n = 0;
    wait_slot(10); oinh_n = 1;
    wait_idle();
    // R10: abort by master reset, then a full word
    q.push_back(16'h3C3C);
    sync_sel = 0; en = 1;
    wait_slot(0); en = 0;
    wait_slot(8);
    mrst = 1;
    repeat (2) @(negedge clk);
    mrst = 0;
    repeat (30) @(negedge clk);
    one_word(0, 16'h0F0F);
    one_word(1, 16'h7FFE);
    finish_run();
  end
endmodule